// File: doc/BRIEF.md
# Dual Port-Group Parallel I/O Register Block

This peripheral gives a host 48 general-purpose pins over a small byte-wide register bus. The pins are split into two groups of 24; each group has three 8-bit ports (A, B, C) and one control register. The host programs pin directions by writing a mode-set word to a group's control register. It drives output levels by writing port latches and samples external levels by reading ports. All ports work in plain static I/O: no strobes, handshakes or interrupts.

The direction of ports A and B is set per whole port. Port C has separate direction controls for its upper and lower nibbles. Pin enables for the external tri-state buffers come from flops, so they switch on a clock edge. Read data is registered and is presented the cycle after the read strobe.

Top module: `pio_dual_ports`

## Requirements
- R1: Offsets 0, 1 and 2 select ports A, B and C of group 0, and offset 3 selects its control register. Offsets 4 to 7 do the same for group 1. Offsets 8 to 15 read as 0x00, and writes to them change no pin or register.
- R2: After reset every pin enable is 0, so all ports are inputs. Every output latch is 0, both control registers read 0x9B, and `bus_rdata` is 0x00.
- R3: A control write with bit 7 set is a mode-set word, in which 1 means input. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C pins 7..4 and bit 0 sets port C pins 3..0. The pin enables take the new value at the clock edge that samples the write.
- R4: A mode-set write clears the three output latches of its group to 0 and leaves the other group untouched.
- R5: A control write with bit 7 clear is ignored: pin enables, output levels and the control readback are unchanged.
- R6: A port write loads that port's latch, and `pin_out` shows the latch from the next cycle, whatever the port's direction.
- R7: A port read returns the `pin_in` level for each input pin and the latch value for each output pin. `bus_rdata` is updated at the edge that samples `bus_rd` and holds its value in cycles without a read.
- R8: A control read returns the whole last mode-set word of that group.
- R9: When `bus_rd` and `bus_wr` are both high at the same address, the read returns the state from before the write, and the write takes effect.
- R10: Pin index = group*24 + port*8 + bit, where port A=0, B=1 and C=2. `pin_out` and `pin_oe` use this numbering, and so does `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | External pin levels |
| pin_out | output | 48 | Output latch values driven to the pins |
| pin_oe | output | 48 | Tri-state enable per pin, 1 = drive |

## Verification
A read and a write can be sampled on the same edge at the same offset. The bench provokes this by raising both strobes at once, first on a port offset and then on a control offset. In each case the data returned must be the latch or mode-set word from before the write. The next plain read must then return the new value, and for the mode-set case the group's latches must already be cleared in that cycle.

// File: rtl/pio_pkg.sv
// Package for the dual port-group I/O block.
// Holds the port width, the control word bit positions and the helper
// that turns a mode-set word into per-pin output enables.
package pio_pkg;
    localparam int PORT_W      = 8;
    localparam int PORTS_PER_G = 3;
    localparam int GROUP_PINS  = PORT_W * PORTS_PER_G;

    // Control word bit positions (1 = input)
    localparam int CB_MODESET = 7;
    localparam int CB_A_IN    = 4;
    localparam int CB_CHI_IN  = 3;
    localparam int CB_B_IN    = 1;
    localparam int CB_CLO_IN  = 0;

    localparam logic [PORT_W-1:0] CTRL_RESET = 8'h9B;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Expand a mode-set word into output enables for one group (1 = drive).
    function automatic logic [GROUP_PINS-1:0] ctrl_to_oe(input logic [PORT_W-1:0] w);
        logic [GROUP_PINS-1:0] oe;
        oe[PORT_W-1:0]          = {PORT_W{~w[CB_A_IN]}};
        oe[2*PORT_W-1:PORT_W]   = {PORT_W{~w[CB_B_IN]}};
        oe[2*PORT_W+3:2*PORT_W] = {4{~w[CB_CLO_IN]}};
        oe[3*PORT_W-1:2*PORT_W+4] = {4{~w[CB_CHI_IN]}};
        return oe;
    endfunction
endpackage

// File: rtl/pio_port_latch.sv
// One output latch of one port.
// Assumes the group has already decoded a write to this port and a
// mode-set write; the mode-set clear wins over a load.
module pio_port_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold, load or clear the latch
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (load) q <= wdata;
    end
endmodule

// File: rtl/pio_group.sv
// One group of three 8-bit ports plus its control register.
// Assumes wr_en is already qualified by the group decode; sel picks the
// port or the control register. Produces registered pin enables and a
// combinational read view, which the top module registers.
module pio_group
    import pio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            sel,
    input  logic [PORT_W-1:0]     wdata,
    input  logic [GROUP_PINS-1:0] pin_in,
    output logic [GROUP_PINS-1:0] pin_out,
    output logic [GROUP_PINS-1:0] pin_oe,
    output logic [PORT_W-1:0]     rd_view
);
    logic [PORT_W-1:0] ctrl_q;
    logic              modeset;
    logic [GROUP_PINS-1:0] mixed;

    assign modeset = wr_en && (sel == SEL_CTRL) && wdata[CB_MODESET];

    // Keep the last mode-set word
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (modeset) ctrl_q <= wdata;
    end

    // Registered tri-state enables, updated on the mode-set edge
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_oe <= '0;
        else if (modeset) pin_oe <= ctrl_to_oe(wdata);
    end

    for (genvar p = 0; p < PORTS_PER_G; p++) begin : g_port
        pio_port_latch #(.W(PORT_W)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (modeset),
            .load  (wr_en && (sel == 2'(p))),
            .wdata (wdata),
            .q     (pin_out[p*PORT_W +: PORT_W])
        );
    end

    assign mixed = (pin_in & ~pin_oe) | (pin_out & pin_oe);

    // Select the port or control view for a read
    always_comb begin
        unique case (sel)
            SEL_A:   rd_view = mixed[0 +: PORT_W];
            SEL_B:   rd_view = mixed[PORT_W +: PORT_W];
            SEL_C:   rd_view = mixed[2*PORT_W +: PORT_W];
            default: rd_view = ctrl_q;
        endcase
    end
endmodule

// File: rtl/pio_dual_ports.sv
// Top: decodes a byte-wide register window into N_GROUPS port groups.
// Each group owns four consecutive offsets; offsets beyond the last group
// read as zero and ignore writes. Read data is registered on the strobe.
module pio_dual_ports
    import pio_pkg::*;
#(
    parameter int N_GROUPS = 2,
    parameter int ADDR_W   = 4,
    localparam int PIN_W   = N_GROUPS * GROUP_PINS,
    localparam int GSEL_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    logic [GSEL_W-1:0] gsel;
    logic [1:0]        rsel;
    logic              in_range;
    logic [7:0]        views [N_GROUPS];
    logic [7:0]        rd_mux;

    assign gsel     = bus_addr[ADDR_W-1:2];
    assign rsel     = bus_addr[1:0];
    assign in_range = int'(gsel) < N_GROUPS;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        pio_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && (gsel == GSEL_W'(g))),
            .sel     (rsel),
            .wdata   (bus_wdata),
            .pin_in  (pin_in[g*GROUP_PINS +: GROUP_PINS]),
            .pin_out (pin_out[g*GROUP_PINS +: GROUP_PINS]),
            .pin_oe  (pin_oe[g*GROUP_PINS +: GROUP_PINS]),
            .rd_view (views[g])
        );
    end

    // Pick the addressed group's read view
    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < N_GROUPS; g++)
            if (gsel == GSEL_W'(g)) rd_mux = views[g];
    end

    // Register read data on the strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= in_range ? rd_mux : 8'h00;
    end
endmodule

// File: rtl/pio_dual_ports_chk.sv
// Checker for pio_dual_ports with the default two groups, attached by bind.
module pio_dual_ports_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [47:0] pin_out,
    input logic [47:0] pin_oe
);
    a_r3_oe_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3 && bus_wdata[7])
        |=> pin_oe[7:0] == {8{~$past(bus_wdata[4])}});

    a_r3_oe_c_high_g1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd7 && bus_wdata[7])
        |=> pin_oe[47:44] == {4{~$past(bus_wdata[3])}});

    a_r4_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3 && bus_wdata[7]) |=> pin_out[23:0] == 24'h0);

    a_r5_plain_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd7 && !bus_wdata[7])
        |=> $stable(pin_oe) && $stable(pin_out));

    a_r6_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd1) |=> pin_out[15:8] == $past(bus_wdata));

    a_r1_high_offsets_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[3]) |=> bus_rdata == 8'h00);

    a_r1_high_offsets_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3]) |=> $stable(pin_out) && $stable(pin_oe));

    a_r7_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r9_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr && bus_addr == 4'd0 && pin_oe[7:0] == 8'hFF)
        |=> bus_rdata == $past(pin_out[7:0]));
endmodule

bind pio_dual_ports pio_dual_ports_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/pio_dual_ports_bench.sv
// Directed bench for pio_dual_ports: one task per scenario.
module pio_dual_ports_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_out;
    logic [47:0] pin_oe;

    int n_total = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pio_dual_ports u_pio_dual_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R2 oe", pin_oe, 48'h0);
        check("R2 out", pin_out, 48'h0);
        check("R2 rdata", {40'h0, bus_rdata}, 48'h0);
        rd(4'd3, d); check("R2 ctrl0", {40'h0, d}, 48'h9B);
        rd(4'd7, d); check("R2 ctrl1", {40'h0, d}, 48'h9B);
    endtask

    task automatic t_modeset();
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 8'h80; bus_wr = 1'b1;
        #1 check("R3 oe before edge", pin_oe, 48'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R3 group0 all out", pin_oe, 48'h0000_00FF_FFFF);
        // group1: A out, B in, C high in, C low out (R10 numbering)
        wr(4'd7, 8'h8A);
        check("R3 R10 group1 mixed", pin_oe, 48'h0F00_FFFF_FFFF);
    endtask

    task automatic t_port_io();
        logic [7:0] d;
        wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd2, 8'h5A);
        check("R6 group0 latches", pin_out[23:0], 48'h5A3CA5);
        rd(4'd0, d); check("R7 output read", {40'h0, d}, 48'hA5);
        pin_in[39:32] = 8'h77;
        wr(4'd5, 8'h11);
        check("R6 latch on input port", {40'h0, pin_out[39:32]}, 48'h11);
        rd(4'd5, d); check("R7 input read", {40'h0, d}, 48'h77);
        pin_in[47:40] = 8'hC3;
        wr(4'd6, 8'h06);
        rd(4'd6, d); check("R7 port C nibble mix", {40'h0, d}, 48'hC6);
        repeat (2) @(negedge clk);
        check("R7 rdata holds", {40'h0, bus_rdata}, 48'hC6);
    endtask

    task automatic t_clear_and_ignore();
        logic [7:0] d;
        logic [47:0] out_before, oe_before;
        wr(4'd4, 8'h44);
        wr(4'd3, 8'h80);
        check("R4 group0 cleared", {24'h0, pin_out[23:0]}, 48'h0);
        check("R4 group1 kept", {24'h0, pin_out[47:24]}, 48'h061144);
        out_before = pin_out; oe_before = pin_oe;
        wr(4'd7, 8'h12);
        check("R5 oe kept", pin_oe, oe_before);
        check("R5 out kept", pin_out, out_before);
        rd(4'd7, d); check("R5 R8 ctrl readback", {40'h0, d}, 48'h8A);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        logic [47:0] out_before, oe_before;
        out_before = pin_out; oe_before = pin_oe;
        wr(4'd9, 8'hFF); wr(4'd15, 8'h80);
        check("R1 high write out", pin_out, out_before);
        check("R1 high write oe", pin_oe, oe_before);
        rd(4'd12, d); check("R1 high read", {40'h0, d}, 48'h0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = 4'd0; bus_wdata = 8'h99; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R9 port old value", {40'h0, bus_rdata}, 48'h00);
        check("R9 port write taken", {40'h0, pin_out[7:0]}, 48'h99);
        rd(4'd0, d); check("R9 port new value", {40'h0, d}, 48'h99);
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 8'h90; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R9 ctrl old word", {40'h0, bus_rdata}, 48'h80);
        check("R9 R4 latches cleared", {24'h0, pin_out[23:0]}, 48'h0);
        rd(4'd3, d); check("R9 R8 ctrl new word", {40'h0, d}, 48'h90);
        check("R3 port A input", {40'h0, pin_oe[7:0]}, 48'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modeset();
        t_port_io();
        t_clear_and_ignore();
        t_unmapped();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule